// File: doc/BRIEF.md
# Timer Clock-Select Prescaler

This block turns the system clock into a count-enable strobe for a timer. A 3-bit select input picks one of eight sources: stop, the system clock divided by 1, 8, 64, 256 or 1024, or single edges of an external clock pin, either rising or falling. The strobe is one system clock wide, so the timer it drives runs entirely in the system clock domain and only advances on cycles where the strobe is high.

Dividing is done by one free-running prescale counter. The counter is cleared on reset, on every change of the select code, and while the timer is stopped. Starting from stop therefore always begins a fresh time base, and the first strobe lands a full period after the change. The external pin is asynchronous. It passes through a two-flop synchroniser, and each synchronised transition of the chosen polarity gives exactly one strobe.

Top module: `clksel_prescaler`

## Requirements
- R1: While `rst_n` is low, `cnt_en` is 0. Reset clears the prescale counter and the stored select code (stored value 0).
- R2: With `clk_sel` = 0 (stop), `cnt_en` stays 0 and the counter is held at zero.
- R3: With `clk_sel` = 1, `cnt_en` is high in every cycle except the cycle in which the select changes.
- R4: With `clk_sel` = 2, 3, 4 or 5 held steady, `cnt_en` is a single-cycle pulse once every 8, 64, 256 or 1024 cycles respectively. The pulse comes when the low log2(N) bits of the counter are all ones.
- R5: With `clk_sel` = 7, each rising edge of `ext_clk` gives exactly one `cnt_en` pulse. Suppose the pin changes before clock edge k. The pulse is then high in the cycle between edges k+1 and k+2.
- R6: With `clk_sel` = 6, each falling edge of `ext_clk` gives exactly one `cnt_en` pulse, with the same latency as R5.
- R7: In a cycle where `clk_sel` differs from the value stored at the previous edge, `cnt_en` is 0 and the counter restarts from zero. For a divider code N, the first pulse is the N-th cycle after that change cycle. This includes leaving stop.
- R8: The external pin is synchronised by two flops followed by one history flop, whatever code is selected. Edges seen while another code is selected can produce a pulse after switching, once the change cycle has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Clock-select code (0 stop, 1..5 divide, 6 falling ext, 7 rising ext) |
| ext_clk | input | 1 | Asynchronous external clock pin |
| cnt_en | output | 1 | One-cycle count-enable strobe for the timer |

## Verification
A counter that is out of step shows as a strobe that lands early or late, and it can stay hidden for up to 1024 cycles at the slowest divider. For that reason the strobe is compared in every cycle against an independent model, and the phase after each select change is counted explicitly. A stale stored select code shows at once as a strobe in the change cycle, or as a missing one. A broken synchroniser stage shows within three cycles of a pin transition, as a pulse that is shifted, doubled or of the wrong polarity.

// File: rtl/presc_pkg.sv
package presc_pkg;
   localparam int unsigned SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_STOP     = 3'd0,
      SEL_DIV1     = 3'd1,
      SEL_DIV8     = 3'd2,
      SEL_DIV64    = 3'd3,
      SEL_DIV256   = 3'd4,
      SEL_DIV1024  = 3'd5,
      SEL_EXT_FALL = 3'd6,
      SEL_EXT_RISE = 3'd7
   } clk_sel_e;

   // log2 of the divide ratio for the divider codes, 0 otherwise
   function automatic int unsigned sel_shift(logic [SEL_W-1:0] code);
      case (code)
         SEL_DIV8:    return 3;
         SEL_DIV64:   return 6;
         SEL_DIV256:  return 8;
         SEL_DIV1024: return 10;
         default:     return 0;
      endcase
   endfunction

   function automatic logic sel_is_div(logic [SEL_W-1:0] code);
      return (code >= SEL_DIV1) && (code <= SEL_DIV1024);
   endfunction
endpackage

// File: rtl/presc_edge_sync.sv
module presc_edge_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   localparam int unsigned CHAIN = SYNC_STAGES + 1;

   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
   end

   logic [CHAIN-1:0] pipe;

   genvar g;
   generate
      for (g = 0; g < CHAIN; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[g] <= 1'b0;
               else        pipe[g] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[g] <= 1'b0;
               else        pipe[g] <= pipe[g-1];
            end
         end
      end
   endgenerate

   assign rise =  pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
   assign fall = ~pipe[SYNC_STAGES-1] &  pipe[SYNC_STAGES];
endmodule

// File: rtl/presc_count.sv
module presc_count
   import presc_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] cnt,
   output logic             sel_chg
);
   logic [SEL_W-1:0] sel_q;

   assign sel_chg = (sel != sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         cnt   <= '0;
      end else begin
         sel_q <= sel;
         if (sel_chg || !sel_is_div(sel)) cnt <= '0;
         else                             cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/presc_tick_select.sv
module presc_tick_select
   import presc_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [CNT_W-1:0] cnt,
   input  logic             sel_chg,
   input  logic             rise,
   input  logic             fall,
   output logic             tick
);
   logic [CNT_W-1:0] mask;

   always_comb begin
      mask = CNT_W'((1 << sel_shift(sel)) - 1);
      tick = 1'b0;
      if (!sel_chg) begin
         case (sel)
            SEL_EXT_FALL: tick = fall;
            SEL_EXT_RISE: tick = rise;
            SEL_STOP:     tick = 1'b0;
            default:      tick = ((cnt & mask) == mask);
         endcase
      end
   end
endmodule

// File: rtl/clksel_prescaler.sv
module clksel_prescaler #(
   parameter int unsigned MAX_DIV_LOG2 = 10,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] clk_sel,
   input  logic       ext_clk,
   output logic       cnt_en
);
   localparam int unsigned CNT_W = MAX_DIV_LOG2;

   initial begin
      if (MAX_DIV_LOG2 < 10) $error("MAX_DIV_LOG2 must cover divide by 1024");
   end

   logic [CNT_W-1:0] cnt;
   logic             sel_chg;
   logic             rise;
   logic             fall;

   presc_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .sel(clk_sel), .cnt(cnt), .sel_chg(sel_chg)
   );

   presc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_clk), .rise(rise), .fall(fall)
   );

   presc_tick_select #(.CNT_W(CNT_W)) u_sel (
      .sel(clk_sel), .cnt(cnt), .sel_chg(sel_chg), .rise(rise), .fall(fall),
      .tick(cnt_en)
   );
endmodule

// File: rtl/clksel_prescaler_chk.sv
module clksel_prescaler_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] clk_sel,
   input logic       cnt_en
);
   // R2
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == 3'd0) |-> !cnt_en);

   // R3
   div1_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(!rst_n) && clk_sel == 3'd1 && $past(clk_sel) == 3'd1) |-> cnt_en);

   // R4
   div_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel >= 3'd2 && clk_sel <= 3'd5 && cnt_en) |=> !cnt_en);

   // R7
   change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(!rst_n) && clk_sel != $past(clk_sel)) |-> !cnt_en);

   // R5
   ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel[2:1] == 2'b11 && cnt_en) |=> !cnt_en);
endmodule

bind clksel_prescaler clksel_prescaler_chk u_chk (
   .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .cnt_en(cnt_en)
);

// File: tb/tb_clksel_prescaler.sv
module tb_clksel_prescaler;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] clk_sel = 3'd1;
   logic       ext_clk = 1'b0;
   logic       cnt_en;

   int n_checks = 0;
   int n_bad = 0;
   bit done = 0;

   clksel_prescaler dut (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk), .cnt_en(cnt_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model built from the requirements
   logic [2:0] m_selq;
   logic [9:0] m_cnt;
   logic [2:0] m_pipe;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_selq <= 3'd0;
         m_cnt  <= 10'd0;
         m_pipe <= 3'd0;
      end else begin
         m_selq <= clk_sel;
         if (clk_sel != m_selq || clk_sel == 3'd0 || clk_sel >= 3'd6) m_cnt <= 10'd0;
         else m_cnt <= m_cnt + 10'd1;
         m_pipe <= {m_pipe[1:0], ext_clk};
      end
   end

   function automatic logic exp_en();
      logic [9:0] mask;
      if (!rst_n || clk_sel != m_selq) return 1'b0;
      case (clk_sel)
         3'd0: return 1'b0;
         3'd1: mask = 10'd0;
         3'd2: mask = 10'd7;
         3'd3: mask = 10'd63;
         3'd4: mask = 10'd255;
         3'd5: mask = 10'd1023;
         3'd6: return !m_pipe[1] && m_pipe[2];
         default: return m_pipe[1] && !m_pipe[2];
      endcase
      return (m_cnt & mask) == mask;
   endfunction

   function automatic string req_of();
      if (!rst_n) return "R1";
      if (clk_sel != m_selq) return "R7";
      case (clk_sel)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd6: return "R6";
         3'd7: return "R5";
         default: return "R4";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   int pulses;

   // sample shortly after the inputs were driven, then move to next negedge
   task automatic step();
      logic e;
      #1;
      e = exp_en();
      if (cnt_en) pulses++;
      check(cnt_en === e, req_of(), int'(cnt_en), int'(e));
      @(negedge clk);
   endtask

   task automatic period_run(input logic [2:0] code, input int n);
      clk_sel = code;
      pulses = 0;
      for (int i = 0; i <= 4*n; i++) step();
      // R4 / R3 / R7: exactly four pulses in 4N cycles after a restart
      check(pulses == 4, code == 3'd1 ? "R3" : "R4", pulses, 4);
   endtask

   task automatic ext_run(input logic [2:0] code, input int edges);
      int exp_p;
      clk_sel = code;
      step();
      step();
      step();
      step();
      pulses = 0;
      exp_p = 0;
      for (int i = 0; i < edges; i++) begin
         ext_clk = ~ext_clk;
         if ((code == 3'd7) == ext_clk) exp_p++;
         for (int k = 0; k < 2 + (i % 3); k++) step();
      end
      for (int k = 0; k < 4; k++) step();
      check(pulses == exp_p, code == 3'd7 ? "R5" : "R6", pulses, exp_p);
   endtask

   initial begin
      void'($urandom(32'h5A17));
      // R1: reset holds strobe low
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         #1 check(cnt_en === 1'b0, "R1", int'(cnt_en), 0);
         @(negedge clk);
      end
      rst_n = 1'b1;
      // R7: first cycle after reset sees select 1 vs stored 0
      step();
      // R2: stop
      clk_sel = 3'd0;
      pulses = 0;
      for (int i = 0; i < 40; i++) step();
      check(pulses == 0, "R2", pulses, 0);
      period_run(3'd1, 1);
      period_run(3'd2, 8);
      period_run(3'd3, 64);
      period_run(3'd4, 256);
      period_run(3'd5, 1024);
      // R7: leave stop, first divide-by-8 pulse is 8 cycles after change
      clk_sel = 3'd0;
      step();
      step();
      clk_sel = 3'd2;
      pulses = 0;
      for (int i = 0; i < 8; i++) step();
      check(pulses == 0, "R7", pulses, 0);
      step();
      check(pulses == 1, "R7", pulses, 1);
      ext_run(3'd7, 20);
      ext_run(3'd6, 20);
      // R8: edge arriving just before switching to rising mode
      clk_sel = 3'd0;
      ext_clk = 1'b0;
      for (int i = 0; i < 5; i++) step();
      ext_clk = 1'b1;
      step();
      clk_sel = 3'd7;
      pulses = 0;
      for (int i = 0; i < 5; i++) step();
      check(pulses == 1, "R8", pulses, 1);
      // random mix of codes and pin activity
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 15) == 0) clk_sel = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 2) == 0) ext_clk = ~ext_clk;
         step();
      end
      done = 1;
   end

   initial begin
      for (int i = 0; i < 150000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end
endmodule